// File: doc/BRIEF.md
# Trimmed Seconds Real-Time Clock Core

This core keeps wall-clock time in whole seconds from a slow reference clock (nominally 32.768 kHz). A prescaler counts reference cycles. Each time it completes one period, a 32-bit seconds count advances by one. Crystal error is corrected digitally. A signed 8-bit trim value shortens or lengthens a single prescaler period, and a programmable interval sets how often that trimmed period is used: once every 1 to 256 seconds. All other seconds last the nominal period.

Software reaches the core through a small synchronous register port with four registers:
- the seconds count;
- the compensation setting (trim and interval);
- a status register holding the counter-run bit;
- a lock register.

The lock register can freeze the compensation setting, and it can also freeze itself until reset. A seconds value of zero is treated as invalid: the core never holds it, never writes it and never counts through it.

Top module: `rtc_trim_core`

## Requirements
- R1: After reset the seconds register reads 1 and the compensation, status and lock registers read 0.
- R2: With a trim of zero, or in any untrimmed second, the seconds count advances once every NOMINAL reference cycles. In a trimmed second it advances after NOMINAL minus the trim, where the trim is read as a signed two's complement byte.
- R3: A positive trim makes the trimmed second shorter and a negative trim makes it longer. The extreme codes are 0x7F, which gives NOMINAL-127 cycles, and 0x80, which gives NOMINAL+128 cycles.
- R4: The interval field holds N and selects a trimmed second every N+1 seconds. After a compensation write, the first whole second is second 1. Second k is trimmed when k >= N and (k-N) is a multiple of N+1, so N=0 trims every second.
- R5: Bit 0 of the status register enables counting. While it is 0, the seconds count and the prescaler hold their values.
- R6: A write to the seconds register while the run bit is 1 is ignored. A write accepted while the run bit is 0 also restarts the prescaler at zero.
- R7: A write of 0 to the seconds register stores 1. The seconds register never holds 0.
- R8: The seconds count wraps from 0xFFFFFFFF to 1.
- R9: While lock bit 0 (compensation lock) is 1, writes to the compensation register are ignored.
- R10: While lock bit 1 (lock-register lock) is 1, writes to the lock register are ignored. While it is 0, the lock bits may be set and cleared.
- R11: The register map is as follows, and all unlisted read bits are 0:
  - address 0: seconds;
  - address 1: compensation, with trim in bits [7:0] and interval in bits [15:8];
  - address 2: status, with run in bit 0;
  - address 3: lock, with the compensation lock in bit 0 and the lock-register lock in bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock (nominally 32.768 kHz) |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for both reads and writes |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data of the addressed register (combinational) |

## Verification
The hardest thing to reach from the ports is the phase of the interval counter relative to second boundaries, because no register reads it back. The bench first waits for a seconds increment. It then writes the compensation register inside the second that follows, which starts a known schedule at the next boundary. After that it timestamps each later increment, so the exact sequence of short, long and nominal seconds can be compared with the R4 formula for several trim and interval pairs. The bench uses a shortened nominal period so that extreme trims and multi-second intervals fit in a short run.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

   localparam int TRIM_W = 8;
   localparam int IVL_W  = 8;
   localparam int CFG_W  = TRIM_W + IVL_W;

   typedef enum logic [1:0] {
      REG_SECS = 2'd0,
      REG_COMP = 2'd1,
      REG_STAT = 2'd2,
      REG_LOCK = 2'd3
   } rtc_reg_e;

   typedef struct packed {
      logic [IVL_W-1:0]  ivl;
      logic [TRIM_W-1:0] trim;
   } comp_cfg_t;

   typedef struct packed {
      logic lock_lock;
      logic comp_lock;
   } lock_t;

endpackage

// File: rtl/rtc_trim_regs.sv
module rtc_trim_regs
   import rtc_trim_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [1:0]        addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output comp_cfg_t         cfg_o,
   output logic              run_o,
   output lock_t             lock_o,
   output logic              secs_load_o,
   output logic              comp_reload_o
);

   comp_cfg_t cfg_q;
   lock_t     lock_q;
   logic      run_q;
   logic      reload_q;

   logic hit_secs, hit_comp, hit_stat, hit_lock;
   logic comp_ok, lock_ok;

   always_comb begin
      hit_secs = wr_en_i && (addr_i == REG_SECS);
      hit_comp = wr_en_i && (addr_i == REG_COMP);
      hit_stat = wr_en_i && (addr_i == REG_STAT);
      hit_lock = wr_en_i && (addr_i == REG_LOCK);
      comp_ok  = hit_comp && !lock_q.comp_lock;
      lock_ok  = hit_lock && !lock_q.lock_lock;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cfg_q    <= '0;
         lock_q   <= '0;
         run_q    <= 1'b0;
         reload_q <= 1'b0;
      end else begin
         reload_q <= comp_ok;
         if (comp_ok) cfg_q  <= comp_cfg_t'(wdata_i[CFG_W-1:0]);
         if (hit_stat) run_q <= wdata_i[0];
         if (lock_ok) lock_q <= lock_t'(wdata_i[1:0]);
      end
   end

   assign cfg_o         = cfg_q;
   assign run_o         = run_q;
   assign lock_o        = lock_q;
   assign secs_load_o   = hit_secs && !run_q;
   assign comp_reload_o = reload_q;

   // R9: the compensation lock freezes the trim and interval setting
   assert_comp_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_q.comp_lock && hit_comp) |=> $stable(cfg_q));

   // R10: the lock-register lock freezes the lock register
   assert_lock_locked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_q.lock_lock && hit_lock) |=> $stable(lock_q));

endmodule

// File: rtl/rtc_trim_sched.sv
module rtc_trim_sched
   import rtc_trim_pkg::*;
#(
   parameter int NOMINAL = 32768,
   parameter int PW      = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  comp_cfg_t     cfg_i,
   input  logic          reload_i,
   input  logic          wrap_i,
   output logic [PW-1:0] term_o
);

   localparam int EW = PW + 2;
   localparam int NOM_M1 = NOMINAL - 1;

   logic [IVL_W-1:0] left_q, left_nxt;
   logic [EW-1:0]    trim_ext, short_term;

   always_comb begin
      left_nxt   = (left_q == '0) ? cfg_i.ivl : left_q - 1'b1;
      trim_ext   = {{(EW-TRIM_W){cfg_i.trim[TRIM_W-1]}}, cfg_i.trim};
      short_term = EW'(NOM_M1) - trim_ext;
      term_o     = (left_nxt == '0) ? short_term[PW-1:0] : PW'(NOM_M1);
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)       left_q <= '0;
      else if (reload_i) left_q <= cfg_i.ivl;
      else if (wrap_i)   left_q <= left_nxt;
   end

endmodule

// File: rtl/rtc_trim_presc.sv
module rtc_trim_presc #(
   parameter int NOMINAL = 32768,
   parameter int PW      = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          run_i,
   input  logic          clr_i,
   input  logic [PW-1:0] term_i,
   output logic          wrap_o
);

   logic [PW-1:0] cnt_q, term_q;

   assign wrap_o = run_i && (cnt_q == term_q);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         term_q <= PW'(NOMINAL - 1);
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (wrap_o) begin
         cnt_q  <= '0;
         term_q <= term_i;
      end else if (run_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R2: the prescaler never runs past the period selected for this second
   assert_presc_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= term_q);

   // R5: a stopped prescaler holds its count
   assert_presc_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_trim_secs.sv
module rtc_trim_secs #(
   parameter int SEC_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic [SEC_W-1:0] load_val_i,
   output logic [SEC_W-1:0] secs_o
);

   logic [SEC_W-1:0] secs_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         secs_q <= SEC_W'(1);
      else if (load_i)
         secs_q <= (load_val_i == '0) ? SEC_W'(1) : load_val_i;
      else if (tick_i)
         secs_q <= (secs_q == '1) ? SEC_W'(1) : secs_q + 1'b1;
   end

   assign secs_o = secs_q;

   // R7: zero is never held
   assert_secs_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      secs_q != '0);

   // R8: the all-ones value is followed by 1
   assert_secs_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && !load_i && secs_q == '1) |=> secs_q == SEC_W'(1));

   // R5: with no tick and no accepted write the count holds
   assert_secs_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !load_i) |=> $stable(secs_q));

endmodule

// File: rtl/rtc_trim_core.sv
module rtc_trim_core
   import rtc_trim_pkg::*;
#(
   parameter int NOMINAL = 32768,
   parameter int SEC_W   = 32,
   parameter int DATA_W  = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [1:0]        addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int PW = $clog2(NOMINAL + 129);

   if (NOMINAL <= 128) begin : g_bad_nominal
      $error("NOMINAL must exceed 128 so every trimmed period stays positive");
   end
   if (DATA_W < SEC_W || DATA_W < CFG_W) begin : g_bad_data
      $error("DATA_W must hold the seconds and compensation registers");
   end

   comp_cfg_t        cfg;
   lock_t            lock;
   logic             run, secs_load, comp_reload, wrap;
   logic [PW-1:0]    term_nxt;
   logic [SEC_W-1:0] secs;

   rtc_trim_regs #(.DATA_W(DATA_W)) regs_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .cfg_o(cfg), .run_o(run), .lock_o(lock),
      .secs_load_o(secs_load), .comp_reload_o(comp_reload)
   );

   rtc_trim_sched #(.NOMINAL(NOMINAL), .PW(PW)) sched_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg), .reload_i(comp_reload),
      .wrap_i(wrap), .term_o(term_nxt)
   );

   rtc_trim_presc #(.NOMINAL(NOMINAL), .PW(PW)) presc_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .clr_i(secs_load),
      .term_i(term_nxt), .wrap_o(wrap)
   );

   rtc_trim_secs #(.SEC_W(SEC_W)) secs_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(wrap), .load_i(secs_load),
      .load_val_i(wdata_i[SEC_W-1:0]), .secs_o(secs)
   );

   always_comb begin
      unique case (rtc_reg_e'(addr_i))
         REG_SECS: rdata_o = DATA_W'(secs);
         REG_COMP: rdata_o = DATA_W'(cfg);
         REG_STAT: rdata_o = DATA_W'(run);
         default:  rdata_o = DATA_W'(lock);
      endcase
   end

endmodule

// File: tb/rtc_trim_core_tb.sv
module rtc_trim_core_tb_top;

   localparam int NOM = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rtc_trim_core #(.NOMINAL(NOM)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = 2'd0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
      addr = 2'd0;
   endtask

   task automatic wait_tick(output int stamp, output logic [31:0] val);
      logic [31:0] old;
      bit seen;
      seen = 1'b0;
      @(negedge clk);
      addr = 2'd0;
      #1 old = rdata;
      stamp = cyc; val = old;
      for (int i = 0; i < 1000 && !seen; i++) begin
         @(negedge clk);
         #1;
         if (rdata != old) begin
            seen = 1'b1; stamp = cyc; val = rdata;
         end
      end
      if (!seen) check(1'b0, "R5 tick timeout", 0, 1);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(2'd0, v); check(v == 1, "R1 seconds", v, 1);
      rd(2'd1, v); check(v == 0, "R1 comp", v, 0);
      rd(2'd2, v); check(v == 0, "R1 status", v, 0);
      rd(2'd3, v); check(v == 0, "R1 lock", v, 0);
   endtask

   task automatic t_secs_write;
      logic [31:0] v;
      wr(2'd0, 32'd0);
      rd(2'd0, v); check(v == 1, "R7 zero write", v, 1);
      wr(2'd0, 32'd77);
      rd(2'd0, v); check(v == 77, "R11 seconds write", v, 77);
   endtask

   task automatic t_hold;
      logic [31:0] a, b;
      rd(2'd0, a);
      repeat (3 * NOM) @(negedge clk);
      rd(2'd0, b); check(a == b, "R5 hold while stopped", b, a);
   endtask

   task automatic t_nominal;
      int s0, s1;
      logic [31:0] v, v2;
      wr(2'd2, 32'd1);
      rd(2'd2, v); check(v == 1, "R11 status run", v, 1);
      wait_tick(s0, v);
      for (int k = 0; k < 3; k++) begin
         wait_tick(s1, v2);
         check(s1 - s0 == NOM, "R2 nominal period", s1 - s0, NOM);
         check(v2 == v + 1, "R2 increment by one", v2, v + 1);
         s0 = s1; v = v2;
      end
   endtask

   task automatic t_running_write;
      int s;
      logic [31:0] v, w;
      wait_tick(s, v);
      wr(2'd0, 32'd1234);
      rd(2'd0, w); check(w == v, "R6 write while running ignored", w, v);
   endtask

   task automatic t_trim(input logic [7:0] trim, input int ivl, input int n, input string req);
      int s0, s1, tr, exp;
      logic [31:0] v;
      bit hit;
      tr = int'($signed(trim));
      wait_tick(s0, v);
      wr(2'd1, {16'd0, 8'(ivl), trim});
      rd(2'd1, v);
      check(v == {16'd0, 8'(ivl), trim}, "R11 comp readback", v, {16'd0, 8'(ivl), trim});
      wait_tick(s0, v);
      for (int k = 1; k <= n; k++) begin
         wait_tick(s1, v);
         hit = (k >= ivl) && (((k - ivl) % (ivl + 1)) == 0);
         exp = hit ? NOM - tr : NOM;
         check(s1 - s0 == exp, req, s1 - s0, exp);
         s0 = s1;
      end
   endtask

   task automatic t_wrap;
      int s;
      logic [31:0] v;
      wr(2'd2, 32'd0);
      wr(2'd1, 32'd0);
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, v); check(v == 32'hFFFF_FFFF, "R8 preload", v, 32'hFFFF_FFFF);
      wr(2'd2, 32'd1);
      wait_tick(s, v);
      check(v == 1, "R8 wrap to one", v, 1);
   endtask

   task automatic t_comp_lock;
      logic [31:0] v;
      wr(2'd1, 32'h0000_0203);
      wr(2'd3, 32'd1);
      rd(2'd3, v); check(v == 1, "R9 lock set", v, 1);
      wr(2'd1, 32'h0000_0910);
      rd(2'd1, v); check(v == 32'h0203, "R9 comp write ignored", v, 32'h0203);
      wr(2'd3, 32'd0);
      rd(2'd3, v); check(v == 0, "R10 lock clear while unlocked", v, 0);
      wr(2'd1, 32'h0000_0910);
      rd(2'd1, v); check(v == 32'h0910, "R9 comp write after unlock", v, 32'h0910);
   endtask

   task automatic t_lock_lock;
      logic [31:0] v;
      wr(2'd3, 32'd3);
      wr(2'd3, 32'd0);
      rd(2'd3, v); check(v == 3, "R10 lock write ignored", v, 3);
      wr(2'd1, 32'h0000_0001);
      rd(2'd1, v); check(v == 32'h0910, "R9 comp frozen under lock", v, 32'h0910);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog", cyc, 200000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_secs_write();
      t_hold();
      t_nominal();
      t_running_write();
      t_trim(8'h05, 0, 3, "R2 trim +5 every second");
      t_trim(8'hFD, 2, 5, "R4 trim -3 every third second");
      t_trim(8'h7F, 0, 2, "R3 max positive trim");
      t_trim(8'h80, 0, 2, "R3 max negative trim");
      t_trim(8'h0A, 3, 8, "R4 trim +10 every fourth second");
      t_wrap();
      t_comp_lock();
      t_lock_lock();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule